// File: doc/BRIEF.md
# DMA Channel Service Arbiter

This block decides which of sixteen DMA channels the transfer engine serves next. Each channel presents a service request bit and a 4-bit priority, plus two preemption controls: one that lets the channel be suspended while it runs, and one that stops it from ever suspending another channel. A single mode input selects fixed-priority or round-robin selection. A halt input and a gated debug-stall input hold back new channel starts.

The arbiter tracks one active channel at a time. It emits a one-cycle grant strobe with the channel number, and then stays busy until the engine reports that the active channel is done. The only exception is preemption. In fixed mode, a suspendable active channel yields to a higher-priority requester that is allowed to preempt. In that case the grant strobe comes together with a preempt strobe. In fixed mode the arbiter also checks the sixteen priorities. If any two are equal it raises a configuration error flag and issues no grants.

Top module: `dma_arb`

## Requirements
- R1: While reset is held, and in the first cycle after it, grant_vld_o, grant_ch_o, preempt_o and prio_err_o are all 0.
- R2: With rr_mode_i = 0 (fixed mode) and the arbiter idle, the requesting channel with the numerically largest priority field (channel n uses prio_i[4n+3:4n]) is granted one clock after the request is seen.
- R3: With rr_mode_i = 1, the search starts at the channel after the last granted one and wraps from 15 to 0. After reset, the search starts at channel 0.
- R4: Each grant is a one-cycle pulse on grant_vld_o. After a grant, no further grant is issued until a cycle with done_i = 1, except a preemption grant. The next grant can follow one cycle after that done cycle.
- R5: In fixed mode, preemption happens when the active channel has preempt_en_i set and a channel requests with a strictly higher priority and preempt_dis_i clear. The block then pulses grant_vld_o and preempt_o together. grant_ch_o is the highest-priority such requester, which becomes the active channel.
- R6: An active channel whose preempt_en_i bit is 0 is never preempted, whatever the other requests.
- R7: A requesting channel whose preempt_dis_i bit is 1 never causes a preemption.
- R8: While halt_i = 1, no grant or preemption is issued. Once it returns to 0, pending requests are granted normally.
- R9: With dbg_en_i = 1, an asserted dbg_i stalls every new grant. With dbg_en_i = 0, dbg_i has no effect.
- R10: In fixed mode, if any two priority fields are equal, prio_err_o is 1 one clock later and no grant is issued. In round-robin mode the check is off, so prio_err_o is 0 and grants proceed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 16 | Per-channel service request |
| prio_i | input | 64 | Four priority bits per channel, channel n at [4n+3:4n] |
| preempt_en_i | input | 16 | Channel may be suspended by a higher-priority request |
| preempt_dis_i | input | 16 | Channel may never suspend another channel |
| rr_mode_i | input | 1 | 0 fixed priority, 1 round robin |
| halt_i | input | 1 | Ignore all new service requests |
| dbg_en_i | input | 1 | Enables the debug stall |
| dbg_i | input | 1 | Debug stall request |
| done_i | input | 1 | Active channel has finished |
| grant_vld_o | output | 1 | One-cycle grant strobe |
| grant_ch_o | output | 4 | Granted channel number |
| preempt_o | output | 1 | Grant is a preemption of the active channel |
| prio_err_o | output | 1 | Duplicate priority in fixed mode |

## Verification
Fixed-priority selection is tried with request masks ranging from a single channel to all sixteen. These use a permuted priority set, so the winner is never simply the highest or lowest index, which separates value-based choice from index-based choice. Round-robin is tried with a two-channel pattern spanning channel 15 and channel 0, which exposes wrap and pointer-update faults. Preemption is tried three ways: against a non-suspendable active channel, with a preempt-disabled contender, and then with an eligible contender added, so that each control bit is shown to matter on its own. Halt, debug with and without its enable, and a duplicated priority are each shown to block a grant and then release it.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int ARB_NCH = 16;
  localparam int ARB_PW  = 4;

  typedef enum logic {
    ARB_FIXED = 1'b0,
    ARB_RR    = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/dma_arb_dupchk.sv
module dma_arb_dupchk #(
  parameter int NCH = 16,
  parameter int PW  = 4
) (
  input  logic [NCH*PW-1:0] prio_i,
  output logic              dup_o
);
  logic [NCH-1:0][NCH-1:0] eq;

  for (genvar i = 0; i < NCH; i++) begin : g_row
    for (genvar j = 0; j < NCH; j++) begin : g_col
      if (j > i) begin : g_cmp
        assign eq[i][j] = (prio_i[i*PW +: PW] == prio_i[j*PW +: PW]);
      end else begin : g_zero
        assign eq[i][j] = 1'b0;
      end
    end
  end

  assign dup_o = |eq;
endmodule

// File: rtl/dma_arb_maxpick.sv
module dma_arb_maxpick #(
  parameter int NCH = 16,
  parameter int PW  = 4,
  localparam int CW = $clog2(NCH)
) (
  input  logic [NCH-1:0]    cand_i,
  input  logic [NCH*PW-1:0] prio_i,
  output logic              found_o,
  output logic [CW-1:0]     idx_o
);
  logic [PW-1:0] best;

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    best    = '0;
    for (int i = 0; i < NCH; i++) begin
      if (cand_i[i] && (!found_o || prio_i[i*PW +: PW] > best)) begin
        found_o = 1'b1;
        idx_o   = CW'(i);
        best    = prio_i[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/dma_arb_rrpick.sv
module dma_arb_rrpick #(
  parameter int NCH = 16,
  localparam int CW = $clog2(NCH)
) (
  input  logic [NCH-1:0] cand_i,
  input  logic [CW-1:0]  last_i,
  output logic           found_o,
  output logic [CW-1:0]  idx_o
);
  int unsigned pos;

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    pos     = 0;
    for (int k = 1; k <= NCH; k++) begin
      pos = 32'(last_i) + 32'(k);
      if (pos >= 32'(NCH)) pos = pos - 32'(NCH);
      if (!found_o && cand_i[pos[CW-1:0]]) begin
        found_o = 1'b1;
        idx_o   = pos[CW-1:0];
      end
    end
  end
endmodule

// File: rtl/dma_arb.sv
module dma_arb
  import dma_arb_pkg::*;
#(
  parameter int NCH = ARB_NCH,
  parameter int PW  = ARB_PW,
  localparam int CW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    req_i,
  input  logic [NCH*PW-1:0] prio_i,
  input  logic [NCH-1:0]    preempt_en_i,
  input  logic [NCH-1:0]    preempt_dis_i,
  input  logic              rr_mode_i,
  input  logic              halt_i,
  input  logic              dbg_en_i,
  input  logic              dbg_i,
  input  logic              done_i,
  output logic              grant_vld_o,
  output logic [CW-1:0]     grant_ch_o,
  output logic              preempt_o,
  output logic              prio_err_o
);
  arb_mode_e     mode;
  logic          busy;
  logic [CW-1:0] active_ch;
  logic [CW-1:0] last_ch;
  logic          dup;
  logic          err_now;
  logic          gate;
  logic          fx_found, rr_found, hp_found;
  logic [CW-1:0] fx_idx, rr_idx, hp_idx;
  logic          pick_found;
  logic [CW-1:0] pick_idx;
  logic [PW-1:0] prio_act;
  logic [NCH-1:0] hi_mask;
  logic          new_grant, do_pre;

  assign mode = arb_mode_e'(rr_mode_i);

  dma_arb_dupchk #(.NCH(NCH), .PW(PW)) u_dup (
    .prio_i (prio_i),
    .dup_o  (dup)
  );

  dma_arb_maxpick #(.NCH(NCH), .PW(PW)) u_fix (
    .cand_i  (req_i),
    .prio_i  (prio_i),
    .found_o (fx_found),
    .idx_o   (fx_idx)
  );

  dma_arb_rrpick #(.NCH(NCH)) u_rr (
    .cand_i  (req_i),
    .last_i  (last_ch),
    .found_o (rr_found),
    .idx_o   (rr_idx)
  );

  assign prio_act = prio_i[active_ch*PW +: PW];

  for (genvar c = 0; c < NCH; c++) begin : g_hi
    assign hi_mask[c] = req_i[c] && !preempt_dis_i[c] &&
                        (prio_i[c*PW +: PW] > prio_act);
  end

  dma_arb_maxpick #(.NCH(NCH), .PW(PW)) u_pre (
    .cand_i  (hi_mask),
    .prio_i  (prio_i),
    .found_o (hp_found),
    .idx_o   (hp_idx)
  );

  assign err_now    = (mode == ARB_FIXED) && dup;
  assign gate       = !halt_i && !(dbg_en_i && dbg_i) && !err_now;
  assign pick_found = (mode == ARB_RR) ? rr_found : fx_found;
  assign pick_idx   = (mode == ARB_RR) ? rr_idx : fx_idx;
  assign new_grant  = !busy && gate && pick_found;
  assign do_pre     = busy && gate && (mode == ARB_FIXED) &&
                      preempt_en_i[active_ch] && hp_found;

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_vld_o <= 1'b0;
      grant_ch_o  <= '0;
      preempt_o   <= 1'b0;
      prio_err_o  <= 1'b0;
      busy        <= 1'b0;
      active_ch   <= '0;
      last_ch     <= CW'(NCH - 1);
    end else begin
      grant_vld_o <= new_grant || do_pre;
      preempt_o   <= do_pre;
      prio_err_o  <= err_now;
      if (do_pre) begin
        grant_ch_o <= hp_idx;
        active_ch  <= hp_idx;
        last_ch    <= hp_idx;
      end else if (new_grant) begin
        grant_ch_o <= pick_idx;
        active_ch  <= pick_idx;
        last_ch    <= pick_idx;
        busy       <= 1'b1;
      end else if (busy && done_i) begin
        busy <= 1'b0;
      end
    end
  end

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    grant_vld_o |=> (!grant_vld_o || preempt_o));

  assert_wait_done_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && !done_i) |=> (!grant_vld_o || preempt_o));

  assert_pre_with_grant_R5: assert property (@(posedge clk) disable iff (rst)
    preempt_o |-> grant_vld_o);

  assert_halt_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    halt_i |=> !grant_vld_o);

  assert_dbg_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    (dbg_en_i && dbg_i) |=> !grant_vld_o);

  assert_err_blocks_R10: assert property (@(posedge clk) disable iff (rst)
    prio_err_o |-> !grant_vld_o);
endmodule

// File: tb/dma_arb_bench.sv
module dma_arb_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] req = '0;
  logic [63:0] prio_flat;
  logic [15:0] pe = '1;
  logic [15:0] pd = '0;
  logic        rr = 1'b0;
  logic        halt = 1'b0;
  logic        dbg_en = 1'b0;
  logic        dbg = 1'b0;
  logic        done = 1'b0;
  logic        grant_vld_o;
  logic [3:0]  grant_ch_o;
  logic        preempt_o;
  logic        prio_err_o;
  logic [3:0]  pr [16];
  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dma_arb u_dma_arb (
    .clk(clk), .rst(rst), .req_i(req), .prio_i(prio_flat),
    .preempt_en_i(pe), .preempt_dis_i(pd), .rr_mode_i(rr),
    .halt_i(halt), .dbg_en_i(dbg_en), .dbg_i(dbg), .done_i(done),
    .grant_vld_o(grant_vld_o), .grant_ch_o(grant_ch_o),
    .preempt_o(preempt_o), .prio_err_o(prio_err_o)
  );

  // request mask, expected winner; priorities are (7*n+3) mod 16
  localparam logic [19:0] VEC [8] = '{
    {16'h0001, 4'd0}, {16'hFFFF, 4'd4}, {16'h0005, 4'd0}, {16'h8200, 4'd15},
    {16'h2440, 4'd13}, {16'h0808, 4'd3}, {16'h0102, 4'd8}, {16'h4080, 4'd14}
  };

  task automatic check(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic load_prio();
    for (int i = 0; i < 16; i++) prio_flat[i*4 +: 4] = pr[i];
  endtask

  task automatic do_reset();
    rst = 1'b1; req = '0; done = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R1 reset vld", grant_vld_o, 0);
    check("R1 reset ch", grant_ch_o, 0);
    check("R1 reset pre", preempt_o, 0);
    check("R1 reset err", prio_err_o, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 post-reset vld", grant_vld_o, 0);
  endtask

  task automatic finish_active();
    req = '0; done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  task automatic serve(input logic [15:0] r, input int exp, input string tag);
    req = r;
    @(negedge clk);
    check({tag, " vld"}, grant_vld_o, 1);
    check({tag, " ch"}, grant_ch_o, exp);
    @(negedge clk);
    check("R4 no regrant while busy", grant_vld_o, 0);
    finish_active();
  endtask

  initial begin
    for (int i = 0; i < 16; i++) pr[i] = 4'((7 * i + 3) % 16);
    load_prio();
    do_reset();

    // R2 fixed-priority table
    foreach (VEC[v]) serve(VEC[v][19:4], int'(VEC[v][3:0]), "R2 fixed pick");

    // R3 round robin with wrap
    rr = 1'b1;
    do_reset();
    serve(16'h8001, 0, "R3 rr first");
    serve(16'h8001, 15, "R3 rr next");
    serve(16'h8001, 0, "R3 rr wrap");
    serve(16'h0110, 4, "R3 rr a");
    serve(16'h0110, 8, "R3 rr b");
    serve(16'h0110, 4, "R3 rr c");
    rr = 1'b0;

    // R5 preemption
    do_reset();
    req = 16'h0800; @(negedge clk);
    check("R5 base grant", grant_ch_o, 11);
    req = 16'h0A04; @(negedge clk);
    check("R5 pre vld", grant_vld_o, 1);
    check("R5 pre strobe", preempt_o, 1);
    check("R5 pre ch", grant_ch_o, 9);
    finish_active();

    // R6 non-suspendable active channel
    pe[11] = 1'b0;
    req = 16'h0800; @(negedge clk);
    check("R6 base grant", grant_ch_o, 11);
    req = 16'h0810; @(negedge clk);
    check("R6 no grant", grant_vld_o, 0);
    @(negedge clk);
    check("R6 no preempt", preempt_o, 0);
    check("R6 no grant 2", grant_vld_o, 0);
    req = 16'h0010; done = 1'b1; @(negedge clk);
    done = 1'b0;
    check("R4 none in done cycle", grant_vld_o, 0);
    @(negedge clk);
    check("R4 grant after done", grant_vld_o, 1);
    check("R4 grant after done ch", grant_ch_o, 4);
    finish_active();
    pe[11] = 1'b1;

    // R7 preempt-disabled contender
    pd[4] = 1'b1;
    req = 16'h0800; @(negedge clk);
    check("R7 base grant", grant_ch_o, 11);
    req = 16'h0810; @(negedge clk);
    check("R7 disabled no preempt", preempt_o, 0);
    check("R7 disabled no grant", grant_vld_o, 0);
    req = 16'h2810; @(negedge clk);
    check("R7 eligible preempt", preempt_o, 1);
    check("R7 eligible ch", grant_ch_o, 13);
    finish_active();
    pd[4] = 1'b0;

    // R8 halt
    halt = 1'b1; req = 16'h0001; @(negedge clk);
    check("R8 halted", grant_vld_o, 0);
    @(negedge clk);
    check("R8 halted 2", grant_vld_o, 0);
    halt = 1'b0; @(negedge clk);
    check("R8 resume vld", grant_vld_o, 1);
    check("R8 resume ch", grant_ch_o, 0);
    finish_active();

    // R9 debug stall
    dbg_en = 1'b1; dbg = 1'b1; req = 16'h0001; @(negedge clk);
    check("R9 stalled", grant_vld_o, 0);
    @(negedge clk);
    check("R9 stalled 2", grant_vld_o, 0);
    dbg_en = 1'b0; @(negedge clk);
    check("R9 dbg ignored when disabled", grant_vld_o, 1);
    finish_active();
    dbg = 1'b0;

    // R10 duplicate priorities
    pr[5] = pr[0]; load_prio();
    req = 16'h0010; @(negedge clk);
    check("R10 err flag", prio_err_o, 1);
    check("R10 blocked", grant_vld_o, 0);
    rr = 1'b1; @(negedge clk);
    check("R10 rr no err", prio_err_o, 0);
    check("R10 rr grant", grant_vld_o, 1);
    check("R10 rr ch", grant_ch_o, 4);
    finish_active();
    rr = 1'b0;
    pr[5] = 4'd6; load_prio();
    @(negedge clk);
    check("R10 err cleared", prio_err_o, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule